// File: doc/BRIEF.md
# Serial-Bus Output Port Expander

This block is a synchronous two-wire (I2C) slave that owns an eight-bit push-pull output register. A bus master addresses it, then writes bytes that each replace the whole output register. It can also read back the live levels of the port pins. There is no internal register pointer. Every data byte refers to the full port. On reads, the pins are sampled again at every acknowledge slot, so the data returned is the actual pin state and not the latched output value.

SCL and SDA arrive as raw levels that are oversampled on the system clock. SDA is driven through an open-drain enable: when `sda_pull` is high, the pad pulls the line low. The seven-bit slave address has a fixed upper field of binary 101 and a lower nibble supplied by an external address selector, so the address lies between 0x50 and 0x5F. The same selector supplies the value the port takes at power-on reset. A separate active-low interface reset aborts any transfer in progress and leaves the output register untouched.

Top module: `i2c_outport_expander`

## Requirements
- R1: An address byte whose upper seven bits equal {101, `addr_sel`} is acknowledged by pulling SDA low in the ninth clock. Any other address is not acknowledged, and the slave then ignores the bus until the next START. Bit 0 of the address byte selects the direction: 0 means write, 1 means read.
- R2: In a write, every data byte is acknowledged and replaces all eight bits of `port_out` (MSB first on the wire). Any number of bytes may follow before STOP. `port_out` changes only when such a byte completes.
- R3: In a read, the first byte sent MSB first is `pin_level` as sampled during the address acknowledge. Each later byte is `pin_level` sampled again during the master's acknowledge of the previous byte.
- R4: After the master answers a read byte with NACK (SDA high), the slave keeps SDA released until STOP or START.
- R5: A repeated START in any phase restarts address reception. A partially received data byte is discarded.
- R6: After a STOP the slave is idle. Clock pulses without a START are not acknowledged and leave `port_out` unchanged.
- R7: Holding `bus_rst_n` low aborts the transfer and releases SDA. `port_out` keeps its value. The next START is handled normally.
- R8: While `rst_n` is low, `port_out` takes `pwr_default` and SDA is released.
- R9: `sda_pull` changes only while SCL is low (outside a bus reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low power-on reset |
| bus_rst_n | input | 1 | Active-low serial-interface reset |
| scl_in | input | 1 | Raw SCL level |
| sda_in | input | 1 | Raw SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_sel | input | 4 | Low nibble of the slave address |
| pwr_default | input | 8 | Port value loaded at power-on reset |
| pin_level | input | 8 | Present logic level of the port pins |
| port_out | output | 8 | Push-pull output register |

## Verification
The hardest situation to reach is an abort in the middle of a byte. This covers a bus reset or a repeated START that arrives after only a few data bits, and the check is that the partial byte never reaches the port. The bench uses a bit-level master model that can stop after any number of bits. It pulses the reset or reissues START there, then keeps clocking and confirms both the missing acknowledge and the unchanged port. A full sweep of all sixteen selector values against all sixteen addresses in the 0x5X range covers matching and direction. Reads change `pin_level` between bytes to prove that the pins are resampled.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    L_IDLE, L_ADDR, L_AACK, L_WDATA, L_WACK, L_RDATA, L_RACK, L_WAIT
  } link_st_t;

  // fixed upper field joined with the selector nibble
  function automatic logic [ADDR_W-1:0] full_addr(input logic [2:0] hi,
                                                  input logic [3:0] sel);
    return {hi, sel};
  endfunction

  function automatic logic addr_hit(input logic [BYTE_W-1:0] rx,
                                    input logic [ADDR_W-1:0] own);
    return rx[BYTE_W-1:1] == own;
  endfunction
endpackage

// File: rtl/i2cx_line_sync.sv
module i2cx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic prev
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= din;
        else chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else prev <= chain[STAGES-1];
  end

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/i2cx_cond_detect.sv
module i2cx_cond_detect (
  input  logic scl_s,
  input  logic scl_p,
  input  logic sda_s,
  input  logic sda_p,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_held;
  assign scl_held = scl_s & scl_p;
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_held & sda_p & ~sda_s;
  assign stop_ev  = scl_held & ~sda_p & sda_s;
endmodule

// File: rtl/i2cx_link.sv
module i2cx_link
  import i2cx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] pin_level,
  output logic              sda_pull,
  output logic              wr_load,
  output logic [BYTE_W-1:0] wr_data,
  output link_st_t          link_st
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  link_st_t          st;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh;
  logic              is_rd;
  logic              mack;
  logic              abort;

  assign abort   = !bus_rst_n || stop_ev;
  assign wr_load = !abort && !start_ev && st == L_WDATA && scl_fall && cnt == FULL;
  assign wr_data = sh;
  assign link_st = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= L_IDLE; cnt <= '0; sh <= '0;
      is_rd <= 1'b0; mack <= 1'b0; sda_pull <= 1'b0;
    end else if (abort) begin
      st <= L_IDLE; cnt <= '0; sda_pull <= 1'b0;
    end else if (start_ev) begin
      st <= L_ADDR; cnt <= '0; sda_pull <= 1'b0;
    end else begin
      case (st)
        L_ADDR: begin
          if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == FULL) begin
            cnt <= '0;
            if (addr_hit(sh, own_addr)) begin
              st <= L_AACK; sda_pull <= 1'b1; is_rd <= sh[0];
            end else begin
              st <= L_WAIT;
            end
          end
        end
        L_AACK: begin
          if (scl_rise && is_rd) sh <= pin_level;
          else if (scl_fall) begin
            cnt <= '0;
            if (is_rd) begin st <= L_RDATA; sda_pull <= ~sh[BYTE_W-1]; end
            else begin st <= L_WDATA; sda_pull <= 1'b0; end
          end
        end
        L_WDATA: begin
          if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == FULL) begin
            st <= L_WACK; sda_pull <= 1'b1; cnt <= '0;
          end
        end
        L_WACK: begin
          if (scl_fall) begin st <= L_WDATA; sda_pull <= 1'b0; end
        end
        L_RDATA: begin
          if (scl_fall) begin
            if (cnt == LAST) begin
              st <= L_RACK; sda_pull <= 1'b0; cnt <= '0;
            end else begin
              sh       <= {sh[BYTE_W-2:0], 1'b0};
              sda_pull <= ~sh[BYTE_W-2];
              cnt      <= cnt + 1'b1;
            end
          end
        end
        L_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
            if (!sda_s) sh <= pin_level;
          end else if (scl_fall) begin
            if (mack) begin st <= L_RDATA; sda_pull <= ~sh[BYTE_W-1]; cnt <= '0; end
            else st <= L_WAIT;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cx_port_reg.sv
module i2cx_port_reg
  import i2cx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] pwr_default,
  input  logic              wr_load,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] port_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) port_out <= pwr_default;
    else if (wr_load) port_out <= wr_data;
  end
endmodule

// File: rtl/i2c_outport_expander.sv
module i2c_outport_expander
  import i2cx_pkg::*;
#(
  parameter logic [2:0] ADDR_HI = 3'b101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  input  logic [3:0]        addr_sel,
  input  logic [BYTE_W-1:0] pwr_default,
  input  logic [BYTE_W-1:0] pin_level,
  output logic [BYTE_W-1:0] port_out
);
  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic wr_load;
  logic [BYTE_W-1:0] wr_data;
  logic [ADDR_W-1:0] own_addr;
  link_st_t link_st;

  assign own_addr = full_addr(ADDR_HI, addr_sel);

  i2cx_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .din(scl_in), .lvl(scl_s), .prev(scl_p));
  i2cx_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .din(sda_in), .lvl(sda_s), .prev(sda_p));

  i2cx_cond_detect u_cond (
    .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s), .sda_p(sda_p),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  i2cx_link u_link (
    .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s),
    .own_addr(own_addr), .pin_level(pin_level),
    .sda_pull(sda_pull), .wr_load(wr_load), .wr_data(wr_data),
    .link_st(link_st));

  i2cx_port_reg u_port (
    .clk(clk), .rst_n(rst_n), .pwr_default(pwr_default),
    .wr_load(wr_load), .wr_data(wr_data), .port_out(port_out));
endmodule

// File: rtl/i2cx_checker.sv
module i2cx_checker
  import i2cx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rst_n,
  input logic              scl_s,
  input logic              stop_ev,
  input logic              wr_load,
  input logic              sda_pull,
  input logic [BYTE_W-1:0] port_out,
  input link_st_t          link_st
);
  assert_ack_on_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (link_st == L_AACK && $past(link_st) == L_ADDR) |-> sda_pull);

  assert_port_only_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_out) |-> $past(wr_load));

  assert_release_after_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    link_st == L_WAIT |-> !sda_pull);

  assert_idle_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && bus_rst_n) |=> (link_st == L_IDLE && !sda_pull));

  assert_port_kept_bus_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst_n |=> $stable(port_out));

  assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull) && bus_rst_n && $past(bus_rst_n)) |-> !scl_s);
endmodule

bind i2c_outport_expander i2cx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .scl_s(scl_s),
  .stop_ev(stop_ev), .wr_load(wr_load), .sda_pull(sda_pull),
  .port_out(port_out), .link_st(link_st));

// File: tb/tb_i2c_outport_expander.sv
module tb_i2c_outport_expander;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, bus_rst_n, scl, msda;
  logic [3:0] sel;
  logic [7:0] pdef, pins;
  logic sda_pull;
  logic [7:0] port_out;
  logic sda_line;
  assign sda_line = msda & ~sda_pull;

  int total = 0, bad = 0, r9_viol = 0;
  bit done = 1'b0;
  logic oe_q = 1'b0;

  i2c_outport_expander dut (
    .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .scl_in(scl),
    .sda_in(sda_line), .sda_pull(sda_pull), .addr_sel(sel),
    .pwr_default(pdef), .pin_level(pins), .port_out(port_out));

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input bit b, output bit s);
    msda = b; wt(4); scl = 1'b1; wt(4); s = sda_line; wt(4); scl = 1'b0; wt(4);
  endtask

  task automatic start_c;
    msda = 1'b1; wt(4); scl = 1'b1; wt(8); msda = 1'b0; wt(8); scl = 1'b0; wt(4);
  endtask

  task automatic stop_c;
    msda = 1'b0; wt(4); scl = 1'b1; wt(8); msda = 1'b1; wt(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input bit mack, input logic [7:0] next_pins, output logic [7:0] v);
    bit s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); v[i] = s; end
    pins = next_pins;
    clk_bit(~mack, s);
  endtask

  // R9 monitor at the ports
  always @(negedge clk) begin
    if (rst_n && bus_rst_n && sda_pull != oe_q && scl) r9_viol++;
    oe_q = sda_pull;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ack, s;
    logic [7:0] v, keep;
    rst_n = 1'b0; bus_rst_n = 1'b1; scl = 1'b1; msda = 1'b1;
    sel = 4'd0; pdef = 8'hA5; pins = 8'h00;
    wt(5); rst_n = 1'b1; wt(5);
    chk(port_out == 8'hA5, "R8 reset default", port_out, 8'hA5);
    chk(sda_pull == 1'b0, "R8 sda released", {7'd0, sda_pull}, 8'h00);

    // R1/R2 sweep: every selector against every 0x5X address
    for (int sv = 0; sv < 16; sv++) begin
      sel = 4'(sv);
      for (int a = 0; a < 16; a++) begin
        logic [7:0] d;
        bit hit;
        d = 8'((sv * 16 + a) ^ 8'h3C);
        hit = (a == sv);
        keep = port_out;
        start_c;
        send_byte(8'((80 + a) * 2), ack);
        chk(ack == hit, "R1 address ack", {7'd0, ack}, {7'd0, hit});
        if (hit) begin
          send_byte(d, ack);
          chk(ack && port_out == d, "R2 write byte", port_out, d);
        end else begin
          chk(port_out == keep, "R1 no effect on miss", port_out, keep);
        end
        stop_c;
      end
    end

    // R1 wrong upper field
    sel = 4'd3;
    start_c; send_byte(8'h63 << 1, ack); stop_c;
    chk(!ack, "R1 upper field 110 rejected", {7'd0, ack}, 8'h00);
    start_c; send_byte(8'h13 << 1, ack); stop_c;
    chk(!ack, "R1 upper field 001 rejected", {7'd0, ack}, 8'h00);

    // R2 multi-byte write
    sel = 4'd9;
    start_c; send_byte(8'h59 << 1, ack);
    chk(ack, "R2 addr ack", {7'd0, ack}, 8'h01);
    for (int k = 1; k <= 3; k++) begin
      send_byte(8'(k * 8'h11), ack);
      chk(ack && port_out == 8'(k * 8'h11), "R2 multi-byte", port_out, 8'(k * 8'h11));
    end
    stop_c;

    // R3 read with resampling, R4 after NACK
    pins = 8'h6B;
    start_c; send_byte((8'h59 << 1) | 8'h01, ack);
    chk(ack, "R3 read addr ack", {7'd0, ack}, 8'h01);
    recv_byte(1'b1, 8'hC4, v);
    chk(v == 8'h6B, "R3 first read byte", v, 8'h6B);
    recv_byte(1'b0, 8'h00, v);
    chk(v == 8'hC4, "R3 resampled byte", v, 8'hC4);
    recv_byte(1'b0, 8'h00, v);
    chk(v == 8'hFF, "R4 released after nack", v, 8'hFF);
    stop_c;
    chk(port_out == 8'h33, "R3 read leaves port", port_out, 8'h33);

    // R5 repeated START mid-byte
    pins = 8'h96;
    start_c; send_byte(8'h59 << 1, ack);
    clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
    start_c; send_byte((8'h59 << 1) | 8'h01, ack);
    chk(ack, "R5 restart addr ack", {7'd0, ack}, 8'h01);
    recv_byte(1'b0, 8'h96, v);
    chk(v == 8'h96, "R5 read after restart", v, 8'h96);
    stop_c;
    chk(port_out == 8'h33, "R5 partial byte dropped", port_out, 8'h33);

    // R6 clocks without START after STOP
    scl = 1'b0; wt(4);
    send_byte(8'h59 << 1, ack);
    chk(!ack, "R6 no ack when idle", {7'd0, ack}, 8'h00);
    send_byte(8'h00, ack);
    chk(port_out == 8'h33, "R6 port unchanged", port_out, 8'h33);
    stop_c;

    // R7 bus reset mid-byte
    start_c; send_byte(8'h59 << 1, ack);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
    bus_rst_n = 1'b0; wt(2); bus_rst_n = 1'b1; wt(2);
    chk(sda_pull == 1'b0, "R7 sda released", {7'd0, sda_pull}, 8'h00);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    clk_bit(1'b1, s);
    chk(s == 1'b1, "R7 no ack after abort", {7'd0, s}, 8'h01);
    chk(port_out == 8'h33, "R7 port kept", port_out, 8'h33);
    stop_c;
    start_c; send_byte(8'h59 << 1, ack); send_byte(8'h5A, ack); stop_c;
    chk(port_out == 8'h5A, "R7 recovers", port_out, 8'h5A);

    // R8 second power-on reset
    pdef = 8'h0F; rst_n = 1'b0; wt(3);
    chk(port_out == 8'h0F, "R8 reload default", port_out, 8'h0F);
    rst_n = 1'b1; wt(5);

    chk(r9_viol == 0, "R9 sda change with scl high", 8'(r9_viol), 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule